// File: doc/BRIEF.md
# Burst Beat Wait-State Timer

This block is the per-bank timing engine of a general-purpose external memory controller. For each access it decides in which clock each data beat of a burst ends. It signals the end of each beat with a one-clock beat strobe, and the end of the whole access with a second strobe in the same clock as the final beat strobe. The bank's timing set has four parts: a 4-bit wait count for the first beat, a 3-bit wait code for the later burst beats, a relaxed-timing flag and an external-acknowledge select. This set lives in a small register inside the block. The register is written through a write strobe and is copied into a working snapshot when an access starts.

In internal mode, a down counter times each beat. A beat lasts one clock plus its wait states. Relaxed timing doubles the wait states. A burst wait code with its top bit set is reserved. Such a code is timed as code 3 and sets a sticky configuration error. In external-acknowledge mode the wait fields are ignored. Each beat ends in the clock where the acknowledge input is high. If 256 clocks pass without an acknowledge, a time-out counter aborts the access and sets a sticky error.

The control state machine has four states. IDLE waits for a start. FIRST times the first beat internally. BURST times every later beat internally. ACK waits for the external acknowledge. Its transitions are:
- start-internal: IDLE to FIRST.
- start-external: IDLE to ACK.
- first-to-burst: FIRST to BURST, when the first beat ends and more beats remain.
- burst-next: BURST to BURST, when a beat ends and more beats remain.
- last-beat: FIRST or BURST to IDLE.
- ack-next: ACK to ACK, on an acknowledge when more beats remain.
- ack-last: ACK to IDLE, on the final acknowledge.
- ack-abort: ACK to IDLE, on time-out.

Top module: `burst_wait_timer`

## Requirements
- R1: After reset, busy, beat_done, access_done and all three error flags are low. The bank-0 timing set is first wait 15, burst code 3 (binary 011), relaxed on, external acknowledge off.
- R2: The first beat ends in clock 1+W after the start was sampled, where W is the first-beat wait count.
- R3: Each later beat lasts 1+B clocks, where B is the burst wait code (0 to 3).
- R4: With relaxed timing on, each beat lasts 1+2W clocks for the first beat and 1+2B clocks for later beats.
- R5: A burst code with bit 2 set is timed as code 3. Such a code also sets cfg_err, which stays high until reset.
- R6: The burst_len code gives the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. access_done pulses for one clock, only together with the final beat_done.
- R7: With external acknowledge selected, both wait fields are ignored. Each beat_done coincides with a clock where ta_in is high.
- R8: In external mode, 256 clocks without an acknowledge abort the access. busy then drops without access_done, and ack_timeout is set and stays high until reset.
- R9: A start while busy is ignored: the current access keeps its timing. The same start sets start_err, which stays high until reset.
- R10: The timing set is captured at start. Writes during an access take effect from the next access.
- R11: busy is high from the clock after an accepted start through the clock of the final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the bank timing set |
| cfg_first_wait | input | 4 | First-beat wait count |
| cfg_burst_wait | input | 3 | Burst-beat wait code (1xx reserved) |
| cfg_relax | input | 1 | Relaxed timing (doubles wait states) |
| cfg_ext_ack | input | 1 | Select external transfer acknowledge |
| start | input | 1 | Access start request |
| burst_len | input | 2 | Beat count code (1, 2, 4, 8) |
| ta_in | input | 1 | External transfer acknowledge |
| busy | output | 1 | Access in progress |
| beat_done | output | 1 | Final clock of a beat |
| access_done | output | 1 | Final clock of the access |
| cfg_err | output | 1 | Sticky reserved-code error |
| start_err | output | 1 | Sticky start-while-busy error |
| ack_timeout | output | 1 | Sticky acknowledge time-out error |

## Verification
A wrong wait counter value moves a beat_done strobe by whole clocks. The bench therefore compares every clock of every access against a beat-end schedule it computes itself, which exposes the error at the first misplaced beat. A corrupted beat-remaining count shows as an early or late access_done, or as busy lasting past the computed final clock. A wrong snapshot or ignored start shows up as timing that changes in the middle of an access. A wrong time-out count shows up as busy falling one clock off the 256th clock.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_BURST,
        ST_ACK
    } bwt_state_e;

endpackage

// File: rtl/bwt_cfg_regs.sv
module bwt_cfg_regs #(
    parameter int FIRST_W = 4,
    parameter int BURST_W = 3,
    parameter bit BANK0   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [FIRST_W-1:0] first_in,
    input  logic [BURST_W-1:0] burst_in,
    input  logic               relax_in,
    input  logic               ext_in,
    output logic [FIRST_W-1:0] first_q,
    output logic [BURST_W-1:0] burst_q,
    output logic               relax_q,
    output logic               ext_q
);

    localparam logic [BURST_W-1:0] BURST_MAX_LEGAL = BURST_W'((1 << (BURST_W-1)) - 1);

    logic [FIRST_W-1:0] first_rst;
    logic [BURST_W-1:0] burst_rst;
    logic               relax_rst;

    generate
        if (BANK0) begin : g_bank0
            assign first_rst = '1;
            assign burst_rst = BURST_MAX_LEGAL;
            assign relax_rst = 1'b1;
        end else begin : g_other
            assign first_rst = '0;
            assign burst_rst = '0;
            assign relax_rst = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= first_rst;
            burst_q <= burst_rst;
            relax_q <= relax_rst;
            ext_q   <= 1'b0;
        end else if (we) begin
            first_q <= first_in;
            burst_q <= burst_in;
            relax_q <= relax_in;
            ext_q   <= ext_in;
        end
    end

endmodule

// File: rtl/bwt_wait_calc.sv
module bwt_wait_calc #(
    parameter int CODE_W = 4,
    parameter int OUT_W  = 5,
    parameter bit CLAMP  = 1'b0
) (
    input  logic [CODE_W-1:0] code,
    input  logic              relax,
    output logic [OUT_W-1:0]  waits,
    output logic              reserved
);

    logic [CODE_W-1:0] eff;
    logic [OUT_W-1:0]  wide;

    generate
        if (CLAMP) begin : g_clamp
            assign reserved = code[CODE_W-1];
            assign eff      = reserved ? {1'b0, {(CODE_W-1){1'b1}}} : code;
        end else begin : g_plain
            assign reserved = 1'b0;
            assign eff      = code;
        end
    endgenerate

    assign wide  = OUT_W'(eff);
    assign waits = relax ? (wide << 1) : wide;

endmodule

// File: rtl/bwt_down_ctr.sv
module bwt_down_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/bwt_ack_timer.sv
module bwt_ack_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expire
);

    localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && (cnt_q == LAST);

endmodule

// File: rtl/burst_wait_timer.sv
module burst_wait_timer
    import bwt_pkg::*;
#(
    parameter int FIRST_W    = 4,
    parameter int BURST_W    = 3,
    parameter int LEN_CODE_W = 2,
    parameter int ACK_LIMIT  = 256,
    parameter bit BANK0      = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [FIRST_W-1:0]    cfg_first_wait,
    input  logic [BURST_W-1:0]    cfg_burst_wait,
    input  logic                  cfg_relax,
    input  logic                  cfg_ext_ack,
    input  logic                  start,
    input  logic [LEN_CODE_W-1:0] burst_len,
    input  logic                  ta_in,
    output logic                  busy,
    output logic                  beat_done,
    output logic                  access_done,
    output logic                  cfg_err,
    output logic                  start_err,
    output logic                  ack_timeout
);

    localparam int WAIT_W    = ((FIRST_W > BURST_W) ? FIRST_W : BURST_W) + 1;
    localparam int MAX_BEATS = 1 << ((1 << LEN_CODE_W) - 1);
    localparam int BL_W      = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

    bwt_state_e state_q, state_d;

    logic [FIRST_W-1:0] cfg_first_q;
    logic [BURST_W-1:0] cfg_burst_q;
    logic               cfg_relax_q;
    logic               cfg_ext_q;

    logic [BURST_W-1:0] act_burst_q;
    logic               act_relax_q;
    logic               act_ext_q;
    logic [BL_W-1:0]    beats_left_q;

    logic [WAIT_W-1:0]  first_waits;
    logic [WAIT_W-1:0]  burst_waits;
    logic               first_rsv;
    logic               burst_rsv;

    logic               accept;
    logic               cnt_zero;
    logic               beat_end;
    logic               last_beat;
    logic               abort;
    logic               expire;
    logic               ctr_load;
    logic [WAIT_W-1:0]  ctr_val;
    logic               ctr_dec;
    logic [BL_W:0]      len_beats;

    bwt_cfg_regs #(
        .FIRST_W (FIRST_W),
        .BURST_W (BURST_W),
        .BANK0   (BANK0)
    ) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .first_in (cfg_first_wait),
        .burst_in (cfg_burst_wait),
        .relax_in (cfg_relax),
        .ext_in   (cfg_ext_ack),
        .first_q  (cfg_first_q),
        .burst_q  (cfg_burst_q),
        .relax_q  (cfg_relax_q),
        .ext_q    (cfg_ext_q)
    );

    bwt_wait_calc #(
        .CODE_W (FIRST_W),
        .OUT_W  (WAIT_W),
        .CLAMP  (1'b0)
    ) i_first_calc (
        .code     (cfg_first_q),
        .relax    (cfg_relax_q),
        .waits    (first_waits),
        .reserved (first_rsv)
    );

    bwt_wait_calc #(
        .CODE_W (BURST_W),
        .OUT_W  (WAIT_W),
        .CLAMP  (1'b1)
    ) i_burst_calc (
        .code     (act_burst_q),
        .relax    (act_relax_q),
        .waits    (burst_waits),
        .reserved (burst_rsv)
    );

    bwt_down_ctr #(
        .W (WAIT_W)
    ) i_beat_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .dec      (ctr_dec),
        .zero     (cnt_zero)
    );

    bwt_ack_timer #(
        .LIMIT (ACK_LIMIT)
    ) i_ack_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept || (state_q == ST_ACK && ta_in)),
        .run    (state_q == ST_ACK && !ta_in),
        .expire (expire)
    );

    assign accept    = start && (state_q == ST_IDLE);
    assign last_beat = (beats_left_q == '0);
    assign beat_end  = ((state_q == ST_FIRST || state_q == ST_BURST) && cnt_zero) ||
                       (state_q == ST_ACK && ta_in);
    assign abort     = (state_q == ST_ACK) && expire;
    assign len_beats = (BL_W+1)'(1) << burst_len;

    // Beat counter control: first beat from live set, later beats from snapshot.
    assign ctr_load = (accept && !cfg_ext_q) ||
                      (beat_end && !last_beat && !act_ext_q);
    assign ctr_val  = accept ? first_waits : burst_waits;
    assign ctr_dec  = (state_q == ST_FIRST || state_q == ST_BURST) && !cnt_zero;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = cfg_ext_q ? ST_ACK : ST_FIRST;
                end
            end
            ST_FIRST, ST_BURST: begin
                if (cnt_zero) begin
                    state_d = last_beat ? ST_IDLE : ST_BURST;
                end
            end
            ST_ACK: begin
                if (ta_in) begin
                    if (last_beat) begin
                        state_d = ST_IDLE;
                    end
                end else if (expire) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Access snapshot and beat bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_burst_q  <= '0;
            act_relax_q  <= 1'b0;
            act_ext_q    <= 1'b0;
            beats_left_q <= '0;
        end else if (accept) begin
            act_burst_q  <= cfg_burst_q;
            act_relax_q  <= cfg_relax_q;
            act_ext_q    <= cfg_ext_q;
            beats_left_q <= BL_W'(len_beats - 1'b1);
        end else if (beat_end && !last_beat) begin
            beats_left_q <= beats_left_q - 1'b1;
        end
    end

    // Sticky error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_err     <= 1'b0;
            start_err   <= 1'b0;
            ack_timeout <= 1'b0;
        end else begin
            if (beat_end && !last_beat && !act_ext_q && burst_rsv) begin
                cfg_err <= 1'b1;
            end
            if (start && state_q != ST_IDLE) begin
                start_err <= 1'b1;
            end
            if (abort) begin
                ack_timeout <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        beat_done   = beat_end;
        access_done = beat_end && last_beat;
    end

    logic unused_ok;
    assign unused_ok = first_rsv;

endmodule

// File: rtl/bwt_checker.sv
module bwt_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic ta_in,
    input logic busy,
    input logic beat_done,
    input logic access_done,
    input logic cfg_err,
    input logic start_err,
    input logic ack_timeout,
    input logic act_ext
);

    // R6
    done_with_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_done |-> beat_done);

    // R11
    beat_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |-> busy);

    // R11
    start_makes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R9
    busy_start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> start_err);

    // R5
    cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R8
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_timeout |=> ack_timeout);

    // R8
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_timeout) |-> !busy);

    // R7
    ext_beat_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ext && beat_done) |-> ta_in);

endmodule

bind burst_wait_timer bwt_checker i_bwt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ta_in       (ta_in),
    .busy        (busy),
    .beat_done   (beat_done),
    .access_done (access_done),
    .cfg_err     (cfg_err),
    .start_err   (start_err),
    .ack_timeout (ack_timeout),
    .act_ext     (act_ext_q)
);

// File: tb/test_burst_wait_timer.sv
module test_burst_wait_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_first_wait = '0;
    logic [2:0] cfg_burst_wait = '0;
    logic       cfg_relax = 1'b0;
    logic       cfg_ext_ack = 1'b0;
    logic       start = 1'b0;
    logic [1:0] burst_len = '0;
    logic       ta_in = 1'b0;
    logic       busy, beat_done, access_done, cfg_err, start_err, ack_timeout;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    burst_wait_timer i_burst_wait_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_first_wait (cfg_first_wait),
        .cfg_burst_wait (cfg_burst_wait),
        .cfg_relax      (cfg_relax),
        .cfg_ext_ack    (cfg_ext_ack),
        .start          (start),
        .burst_len      (burst_len),
        .ta_in          (ta_in),
        .busy           (busy),
        .beat_done      (beat_done),
        .access_done    (access_done),
        .cfg_err        (cfg_err),
        .start_err      (start_err),
        .ack_timeout    (ack_timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        cfg_we = 1'b0;
        ta_in = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic write_cfg(input int fw, input int bw, input bit rx, input bit ex);
        cfg_first_wait = 4'(fw);
        cfg_burst_wait = 3'(bw);
        cfg_relax = rx;
        cfg_ext_ack = ex;
        cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    // Internal-mode access. pert: 0 none, 1 start pulse at cycle pc, 2 cfg write at cycle pc.
    task automatic run_int(input int fw, input int bw, input bit rx, input int lc,
                           input bit wr, input int pert, input int pc, input string req);
        int mul, eb, l1, lb, n, total;
        mul = rx ? 2 : 1;
        eb = (bw >= 4) ? 3 : bw;
        l1 = 1 + fw * mul;
        lb = 1 + eb * mul;
        n = 1 << lc;
        total = l1 + (n - 1) * lb;
        if (wr) write_cfg(fw, bw, rx, 1'b0);
        burst_len = 2'(lc);
        start = 1'b1;
        step();
        start = 1'b0;
        for (int c = 1; c <= total + 2; c++) begin
            bit exp_end;
            exp_end = (c == l1) || (c > l1 && c <= total && ((c - l1) % lb) == 0);
            chk(beat_done == exp_end, req, $sformatf("beat_done cycle %0d", c), beat_done, exp_end);
            chk(access_done == (c == total), req, $sformatf("access_done cycle %0d", c),
                access_done, (c == total));
            chk(busy == (c <= total), "R11", $sformatf("busy cycle %0d", c), busy, (c <= total));
            start = (pert == 1 && c == pc);
            if (pert == 2 && c == pc) begin
                cfg_first_wait = '0; cfg_burst_wait = '0; cfg_relax = 1'b0; cfg_ext_ack = 1'b0;
                cfg_we = 1'b1;
            end else begin
                cfg_we = 1'b0;
            end
            step();
        end
        start = 1'b0;
        cfg_we = 1'b0;
    endtask

    // R1: reset state and bank-0 defaults (first 15, burst 3, relaxed): 31 then 7 clocks
    task automatic t_reset();
        do_reset();
        chk(busy == 0, "R1", "busy after reset", busy, 0);
        chk(beat_done == 0 && access_done == 0, "R1", "strobes after reset", beat_done, 0);
        chk(cfg_err == 0 && start_err == 0 && ack_timeout == 0, "R1", "flags after reset",
            int'(cfg_err) + int'(start_err) + int'(ack_timeout), 0);
        run_int(15, 3, 1'b1, 1, 1'b0, 0, 0, "R1");
    endtask

    task automatic t_normal();
        run_int(2, 1, 1'b0, 2, 1'b1, 0, 0, "R2");
        run_int(5, 3, 1'b0, 1, 1'b1, 0, 0, "R3");
        run_int(0, 0, 1'b0, 3, 1'b1, 0, 0, "R6");
        run_int(4, 2, 1'b0, 0, 1'b1, 0, 0, "R6");
    endtask

    task automatic t_relax();
        run_int(3, 2, 1'b1, 2, 1'b1, 0, 0, "R4");
        run_int(0, 0, 1'b1, 1, 1'b1, 0, 0, "R4");
    endtask

    task automatic t_reserved();
        do_reset();
        chk(cfg_err == 0, "R5", "cfg_err before", cfg_err, 0);
        run_int(1, 5, 1'b0, 1, 1'b1, 0, 0, "R5");
        chk(cfg_err == 1, "R5", "cfg_err after reserved code", cfg_err, 1);
        run_int(1, 7, 1'b1, 1, 1'b1, 0, 0, "R5");
        chk(cfg_err == 1, "R5", "cfg_err sticky", cfg_err, 1);
    endtask

    task automatic t_busy_start();
        do_reset();
        run_int(2, 2, 1'b0, 2, 1'b1, 1, 4, "R9");
        chk(start_err == 1, "R9", "start_err after busy start", start_err, 1);
    endtask

    task automatic t_snapshot();
        do_reset();
        run_int(3, 3, 1'b0, 2, 1'b1, 2, 2, "R10");
        run_int(0, 0, 1'b0, 2, 1'b0, 0, 0, "R10");
    endtask

    // R7: acknowledge delays 0,3,2,1 per beat, wait fields set to long values
    task automatic t_ext();
        int k, w, d, n;
        do_reset();
        write_cfg(9, 3, 1'b1, 1'b1);
        n = 4;
        burst_len = 2'd2;
        start = 1'b1;
        step();
        start = 1'b0;
        k = 0;
        w = 0;
        while (k < n) begin
            d = (k * 3) % 4;
            ta_in = (w == d);
            #2;
            chk(beat_done == ta_in, "R7", $sformatf("beat_done beat %0d wait %0d", k, w),
                beat_done, ta_in);
            chk(access_done == (ta_in && k == n - 1), "R7", "access_done ext",
                access_done, (ta_in && k == n - 1));
            if (ta_in) begin
                k++;
                w = 0;
            end else begin
                w++;
            end
            step();
        end
        ta_in = 1'b0;
        chk(busy == 0, "R7", "busy after last ack", busy, 0);
        chk(ack_timeout == 0, "R8", "no timeout on served access", ack_timeout, 0);
    endtask

    task automatic t_timeout();
        int seen_done;
        do_reset();
        write_cfg(0, 0, 1'b0, 1'b1);
        burst_len = 2'd1;
        ta_in = 1'b0;
        start = 1'b1;
        step();
        start = 1'b0;
        seen_done = 0;
        for (int c = 1; c <= 257; c++) begin
            if (beat_done || access_done) seen_done++;
            if (c == 256) begin
                chk(busy == 1, "R8", "busy in clock 256", busy, 1);
                chk(ack_timeout == 0, "R8", "timeout early", ack_timeout, 0);
            end
            if (c == 257) begin
                chk(busy == 0, "R8", "busy after abort", busy, 0);
                chk(ack_timeout == 1, "R8", "ack_timeout set", ack_timeout, 1);
            end
            if (c < 257) step();
        end
        chk(seen_done == 0, "R8", "strobes during abort", seen_done, 0);
        repeat (3) step();
        chk(ack_timeout == 1, "R8", "ack_timeout sticky", ack_timeout, 1);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_relax();
        t_reserved();
        t_busy_start();
        t_snapshot();
        t_ext();
        t_timeout();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule